// File: doc/BRIEF.md
# Byte-Wide UV-Erasable Read-Only Memory Target Model

This block is a cycle-based, synthesizable stand-in for a byte-wide ultraviolet-erasable read-only memory. A testbench or a larger emulation fabric uses it as a bus target. Two active-low strobes, a chip select and an output gate, set what the data lines do. A flag for a raised programming supply and a flag for high voltage on address bit 9 pick the programming and identification modes. An erase command restores the whole array. The data bus comes out as a value plus an enable, so the instantiating level can build the three-state driver. A separate flag reports when the driven value has met the modelled access times.

Storage starts erased, with every bit set. A programming pulse can only clear bits: the byte stored is the old byte ANDed with the data applied. The pulse is the time the chip select is held low while the programming supply is raised and the output gate is high. The address and data are captured in the first cycle of the pulse. The write takes effect when the chip select returns high, provided the supply is still raised and the gate is still high. Access delays are counted in clock cycles, separately for the address, the chip select and the output gate. The array depth is a parameter so that simulation can use a small array.

Top module: `eprom_model`

## Requirements
- R1: Read: with `vpp_hi`=0, `a9_hv`=0, `ce_n`=0 and `oe_n`=0, `dout_en` is 1 and `dout` equals the byte stored at the low `$clog2(DEPTH)` bits of `addr`.
- R2: Output disable: with `vpp_hi`=0, `ce_n`=0 and `oe_n`=1, `dout_en` is 0.
- R3: Standby: with `vpp_hi`=0 and `ce_n`=1, `dout_en` is 0 whatever the value of `oe_n`.
- R4: After reset, and after an accepted erase, every location reads FFh.
- R5: Program: with `vpp_hi`=1, `ce_n`=0 and `oe_n`=1, `dout_en` is 0 and the first cycle captures `addr` and `din`. When `ce_n` returns to 1 with `vpp_hi`=1 and `oe_n`=1, the captured location becomes old AND `din`. A pulse that ends any other way, such as `vpp_hi` falling or `oe_n` falling, leaves the array unchanged.
- R6: Verify: with `vpp_hi`=1, `ce_n`=1 and `oe_n`=0, the stored byte is driven. `dout_valid` does not wait on the chip-select delay.
- R7: Optional verify: with `vpp_hi`=1, `ce_n`=0 and `oe_n`=0, the stored byte is driven.
- R8: Program inhibit: with `vpp_hi`=1, `ce_n`=1 and `oe_n`=1, `dout_en` is 0 and no location changes.
- R9: Identification: with `a9_hv`=1, `vpp_hi`=0, `ce_n`=0 and `oe_n`=0, `dout` is 20h when `addr[0]`=0 and 04h when `addr[0]`=1.
- R10: `dout_valid` is 1 only when `dout_en` is 1 and all of these hold:
  - `oe_n` has been 0 at the last `T_OE` rising edges;
  - `addr` has been unchanged at the last `T_ACC` rising edges and since the last one;
  - `ce_n` has been 0 at the last `T_CE` rising edges, except in verify.
- R11: `erase`=1 at a rising edge restores every location to FFh in that one cycle. The command is ignored while a program pulse is in progress.
- R12: Whenever `dout_en` is 0, `dout` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst | input | 1 | Synchronous active-high reset; erases the array |
| addr | input | ADDR_W | Byte address |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| din | input | DATA_W | Data applied during programming |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hv | input | 1 | High voltage present on address bit 9 |
| erase | input | 1 | Erase whole array |
| dout | output | DATA_W | Data driven toward the bus |
| dout_en | output | 1 | Bus driver enable |
| dout_valid | output | 1 | Driven data has met the access delays |

## Verification
The hardest state to reach from the ports is an erase command that lands inside a program pulse. The bench produces it by asserting `erase` for one edge while the chip select is held low with the supply raised. It then ends the pulse normally and reads back two bytes. The one programmed before the pulse must be untouched, and the one targeted by the pulse must hold its new value. Aborted pulses are reached by dropping the supply mid-pulse. The access delays are checked at the exact edge on which `dout_valid` may first rise, for each of the three counters.

// File: rtl/eprom_model_pkg.sv
package eprom_model_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY = 3'd0,
        MD_DISABLE = 3'd1,
        MD_READ    = 3'd2,
        MD_IDENT   = 3'd3,
        MD_PROG    = 3'd4,
        MD_VERIFY  = 3'd5,
        MD_OPTVER  = 3'd6,
        MD_INHIBIT = 3'd7
    } eprom_mode_e;

    localparam logic [7:0] MAKER_CODE = 8'h20;
    localparam logic [7:0] PART_CODE  = 8'h04;

    typedef struct packed {
        logic drive;
        logic ident;
        logic need_ce;
    } bus_ctl_t;

    function automatic eprom_mode_e decode_mode(input logic ce_n, input logic oe_n,
                                                input logic vpp_hi, input logic a9_hv);
        eprom_mode_e m;
        if (vpp_hi) begin
            case ({ce_n, oe_n})
                2'b01:   m = MD_PROG;
                2'b10:   m = MD_VERIFY;
                2'b00:   m = MD_OPTVER;
                default: m = MD_INHIBIT;
            endcase
        end else if (ce_n) begin
            m = MD_STANDBY;
        end else if (oe_n) begin
            m = MD_DISABLE;
        end else if (a9_hv) begin
            m = MD_IDENT;
        end else begin
            m = MD_READ;
        end
        return m;
    endfunction

    function automatic bus_ctl_t mode_bus(input eprom_mode_e m);
        bus_ctl_t c;
        c.drive   = (m == MD_READ) || (m == MD_IDENT) || (m == MD_VERIFY) || (m == MD_OPTVER);
        c.ident   = (m == MD_IDENT);
        c.need_ce = (m != MD_VERIFY);
        return c;
    endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_model_pkg::*;
(
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        vpp_hi,
    input  logic        a9_hv,
    output eprom_mode_e mode,
    output bus_ctl_t    bus
);
    always_comb begin
        mode = decode_mode(ce_n, oe_n, vpp_hi, a9_hv);
        bus  = mode_bus(mode);
    end
endmodule

// File: rtl/eprom_hold_cnt.sv
module eprom_hold_cnt #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic restart,
    output logic ok
);
    localparam int CW = $clog2(LIMIT + 1) + 1;
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !hold) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= CW'(1);
        end else if (cnt < LIM) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign ok = hold && !restart && (cnt >= LIM);
endmodule

// File: rtl/eprom_prog_ctl.sv
module eprom_prog_ctl
    import eprom_model_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  eprom_mode_e       mode,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] din,
    output logic              busy,
    output logic              commit,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);
    logic active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else if (mode == MD_PROG) begin
            if (!active) begin
                wr_idx  <= idx;
                wr_data <= din;
            end
            active <= 1'b1;
        end else begin
            active <= 1'b0;
        end
    end

    assign commit = active && (mode == MD_INHIBIT);
    assign busy   = active || (mode == MD_PROG);
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wipe,
    input  logic              wr,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (wr) begin
            cells[wr_idx] <= cells[wr_idx] & wr_data;
        end
    end

    assign rd_data = cells[rd_idx];
endmodule

// File: rtl/eprom_model.sv
module eprom_model
    import eprom_model_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int T_ACC  = 4,
    parameter int T_CE   = 3,
    parameter int T_OE   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] din,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic              erase,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              dout_valid
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    eprom_mode_e       mode;
    bus_ctl_t          bus;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] addr_q;
    logic              addr_moved;
    logic              acc_ok, ce_ok, oe_ok;
    logic              busy, commit;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data, rd_data, ident_byte;

    assign idx = addr[IDX_W-1:0];

    eprom_mode_dec u_dec (
        .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi), .a9_hv(a9_hv),
        .mode(mode), .bus(bus)
    );

    always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else     addr_q <= addr;
    end
    assign addr_moved = (addr != addr_q);

    eprom_hold_cnt #(.LIMIT(T_ACC)) u_acc_cnt (
        .clk(clk), .rst(rst), .hold(1'b1), .restart(addr_moved), .ok(acc_ok)
    );
    eprom_hold_cnt #(.LIMIT(T_CE)) u_ce_cnt (
        .clk(clk), .rst(rst), .hold(!ce_n), .restart(1'b0), .ok(ce_ok)
    );
    eprom_hold_cnt #(.LIMIT(T_OE)) u_oe_cnt (
        .clk(clk), .rst(rst), .hold(!oe_n), .restart(1'b0), .ok(oe_ok)
    );

    eprom_prog_ctl #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_prog (
        .clk(clk), .rst(rst), .mode(mode), .idx(idx), .din(din),
        .busy(busy), .commit(commit), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    eprom_cell_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
        .clk(clk), .rst(rst), .wipe(erase && !busy), .wr(commit),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(idx), .rd_data(rd_data)
    );

    generate
        if (DATA_W >= 8) begin : g_wide
            assign ident_byte = addr[0] ? DATA_W'(PART_CODE) : DATA_W'(MAKER_CODE);
        end else begin : g_narrow
            assign ident_byte = addr[0] ? PART_CODE[DATA_W-1:0] : MAKER_CODE[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        dout_en = bus.drive;
        if (!bus.drive)     dout = '0;
        else if (bus.ident) dout = ident_byte;
        else                dout = rd_data;
        dout_valid = bus.drive && acc_ok && oe_ok && (ce_ok || !bus.need_ce);
    end
endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              ce_n,
    input logic              oe_n,
    input logic              vpp_hi,
    input logic              a9_hv,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input logic              dout_valid
);
    a_r3_standby_hiz: assert property (@(posedge clk) disable iff (rst)
        (!vpp_hi && ce_n) |-> !dout_en);

    a_r2_disable_hiz: assert property (@(posedge clk) disable iff (rst)
        (!vpp_hi && !ce_n && oe_n) |-> !dout_en);

    a_r5_prog_bus_input: assert property (@(posedge clk) disable iff (rst)
        (vpp_hi && !ce_n && oe_n) |-> !dout_en);

    a_r8_inhibit_hiz: assert property (@(posedge clk) disable iff (rst)
        (vpp_hi && ce_n && oe_n) |-> !dout_en);

    a_r12_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> (dout == '0));

    a_r10_valid_needs_en: assert property (@(posedge clk) disable iff (rst)
        dout_valid |-> dout_en);

    a_r10_addr_move_invalid: assert property (@(posedge clk) disable iff (rst)
        (addr != $past(addr)) |-> !dout_valid);

    a_r10_oe_fall_invalid: assert property (@(posedge clk) disable iff (rst)
        $fell(oe_n) |-> !dout_valid);

    a_r9_ident_maker: assert property (@(posedge clk) disable iff (rst)
        (a9_hv && !vpp_hi && !ce_n && !oe_n && !addr[0]) |-> (dout == DATA_W'(8'h20)));

    a_r9_ident_part: assert property (@(posedge clk) disable iff (rst)
        (a9_hv && !vpp_hi && !ce_n && !oe_n && addr[0]) |-> (dout == DATA_W'(8'h04)));
endmodule

bind eprom_model eprom_model_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .vpp_hi(vpp_hi), .a9_hv(a9_hv), .dout(dout), .dout_en(dout_en),
    .dout_valid(dout_valid)
);

// File: tb/eprom_model_bench.sv
`timescale 1ns/1ps
module eprom_model_bench;
    localparam int AW = 15;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, a9_hv = 1'b0, erase = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en, dout_valid;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    eprom_model #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(64), .T_ACC(4), .T_CE(3), .T_OE(2))
    u_eprom_model (
        .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .din(din),
        .vpp_hi(vpp_hi), .a9_hv(a9_hv), .erase(erase),
        .dout(dout), .dout_en(dout_en), .dout_valid(dout_valid)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic set_pins(input logic c, input logic o, input logic v, input logic h,
                            input logic [AW-1:0] a);
        @(negedge clk);
        ce_n = c; oe_n = o; vpp_hi = v; a9_hv = h; addr = a;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic read_at(input logic [AW-1:0] a, output logic [DW-1:0] d);
        set_pins(1'b0, 1'b0, 1'b0, 1'b0, a);
        edges(6);
        d = dout;
    endtask

    task automatic prog_byte(input logic [AW-1:0] a, input logic [DW-1:0] d);
        set_pins(1'b1, 1'b1, 1'b1, 1'b0, a);
        din = d;
        @(negedge clk); ce_n = 1'b0;
        #1 check("R5 bus off in program", dout_en, 0);
        @(negedge clk); din = 8'h00;
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk); vpp_hi = 1'b0;
    endtask

    task automatic t_reset;
        logic [DW-1:0] d;
        #1;
        check("R3 idle bus off", dout_en, 0);
        check("R12 idle dout zero", dout, 0);
        read_at(15'd0, d);
        check("R4 reset reads FF", d, 8'hFF);
        read_at(15'd63, d);
        check("R4 reset reads FF top", d, 8'hFF);
        check("R1 read drives", dout_en, 1);
    endtask

    task automatic t_program_and;
        logic [DW-1:0] d;
        prog_byte(15'd3, 8'hF0);
        read_at(15'd3, d);
        check("R5 first program", d, 8'hF0);
        prog_byte(15'd3, 8'h3C);
        read_at(15'd3, d);
        check("R5 program ANDs", d, 8'h30);
        read_at(15'd4, d);
        check("R5 neighbour untouched", d, 8'hFF);
    endtask

    task automatic t_modes;
        logic [DW-1:0] d;
        set_pins(1'b0, 1'b1, 1'b0, 1'b0, 15'd3);
        #1 check("R2 output disable", dout_en, 0);
        check("R12 disable dout zero", dout, 0);
        set_pins(1'b1, 1'b0, 1'b0, 1'b0, 15'd3);
        #1 check("R3 standby oe low", dout_en, 0);
        set_pins(1'b1, 1'b1, 1'b0, 1'b0, 15'd3);
        #1 check("R3 standby oe high", dout_en, 0);
        set_pins(1'b1, 1'b0, 1'b1, 1'b0, 15'd3);
        edges(6);
        check("R6 verify drives", dout_en, 1);
        check("R6 verify data", dout, 8'h30);
        check("R6 verify valid without ce", dout_valid, 1);
        set_pins(1'b0, 1'b0, 1'b1, 1'b0, 15'd3);
        edges(6);
        check("R7 optional verify data", dout, 8'h30);
        check("R7 optional verify drives", dout_en, 1);
        set_pins(1'b1, 1'b1, 1'b1, 1'b0, 15'd3);
        din = 8'h00;
        edges(3);
        check("R8 inhibit bus off", dout_en, 0);
        set_pins(1'b1, 1'b1, 1'b0, 1'b0, 15'd3);
        read_at(15'd3, d);
        check("R8 inhibit no write", d, 8'h30);
    endtask

    task automatic t_ident;
        set_pins(1'b0, 1'b0, 1'b0, 1'b1, 15'd0);
        edges(6);
        check("R9 maker code", dout, 8'h20);
        set_pins(1'b0, 1'b0, 1'b0, 1'b1, 15'd1);
        edges(6);
        check("R9 part code", dout, 8'h04);
        check("R9 ident drives", dout_en, 1);
        set_pins(1'b1, 1'b1, 1'b0, 1'b0, 15'd0);
    endtask

    task automatic t_abort;
        logic [DW-1:0] d;
        set_pins(1'b1, 1'b1, 1'b1, 1'b0, 15'd7);
        din = 8'h00;
        @(negedge clk); ce_n = 1'b0;
        @(negedge clk); vpp_hi = 1'b0;
        @(negedge clk); ce_n = 1'b1;
        read_at(15'd7, d);
        check("R5 aborted pulse no write", d, 8'hFF);
    endtask

    task automatic t_erase;
        logic [DW-1:0] d;
        prog_byte(15'd5, 8'h00);
        set_pins(1'b1, 1'b1, 1'b1, 1'b0, 15'd6);
        din = 8'h0F;
        @(negedge clk); ce_n = 1'b0;
        @(negedge clk); erase = 1'b1;
        @(negedge clk); erase = 1'b0;
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk); vpp_hi = 1'b0;
        read_at(15'd5, d);
        check("R11 erase ignored during pulse", d, 8'h00);
        read_at(15'd6, d);
        check("R11 pulse still writes", d, 8'h0F);
        set_pins(1'b1, 1'b1, 1'b0, 1'b0, 15'd6);
        erase = 1'b1;
        @(negedge clk); erase = 1'b0;
        read_at(15'd5, d);
        check("R11 erase restores FF", d, 8'hFF);
        read_at(15'd3, d);
        check("R4 erase restores FF", d, 8'hFF);
    endtask

    task automatic t_timing;
        prog_byte(15'd9, 8'hA5);
        set_pins(1'b0, 1'b1, 1'b0, 1'b0, 15'd9);
        edges(6);
        @(negedge clk); oe_n = 1'b0;
        #1 check("R10 oe just fell", dout_valid, 0);
        edges(1);
        check("R10 oe one edge", dout_valid, 0);
        edges(1);
        check("R10 oe delay met", dout_valid, 1);
        @(negedge clk); addr = 15'd10;
        #1 check("R10 addr moved", dout_valid, 0);
        edges(3);
        check("R10 addr three edges", dout_valid, 0);
        edges(1);
        check("R10 addr delay met", dout_valid, 1);
        check("R1 read erased byte", dout, 8'hFF);
        @(negedge clk); ce_n = 1'b1;
        edges(2);
        @(negedge clk); ce_n = 1'b0;
        #1 check("R10 ce just fell", dout_valid, 0);
        edges(2);
        check("R10 ce two edges", dout_valid, 0);
        edges(1);
        check("R10 ce delay met", dout_valid, 1);
        set_pins(1'b0, 1'b0, 1'b0, 1'b0, 15'd9);
        edges(6);
        check("R1 read programmed byte", dout, 8'hA5);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_program_and();
        t_modes();
        t_ident();
        t_abort();
        t_erase();
        t_timing();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule